// File: doc/BRIEF.md
# Per-Core Interrupt Signalling Gate with Mask and Preemption

This block sits between an interrupt distributor and one processor core. On every cycle it receives the distributor's current best pending candidate (its ID and priority value, where a smaller value means more urgent). It decides whether that candidate may be signalled to the core. Two separate comparisons must both pass. The candidate's priority value must be strictly below a software-written priority threshold. It must also be strictly below the running priority, which is the priority of the interrupt the core is already servicing. The second comparison is skipped when nothing is active. A registered IRQ line carries the result to the core, and the decision is recomputed every cycle, so a more urgent arrival can preempt an interrupt that is in service.

The core claims an interrupt with an acknowledge read. The read returns the candidate's ID in the same cycle, tells the distributor which ID was claimed so that the distributor can clear its pending state, and pushes the claimed priority onto a small active-priority stack. An acknowledge read made when no candidate qualifies returns the reserved ID 1023 and changes nothing. An end-of-interrupt write naming the interrupt on top of the stack pops it, and the running priority falls back to the interrupt below it, or to idle.

Top module: `irq_cpu_gate`

## Requirements
- R1: After reset the threshold is 0, so every candidate is blocked. The IRQ output is low, the running priority reads 255 (idle), and an acknowledge read returns 1023.
- R2: The IRQ output is high in a cycle only if, in the previous cycle, a candidate was valid and its priority value was strictly below the threshold. An equal value is blocked.
- R3: When the stack is not empty, the candidate must also have a priority value strictly below the running priority. When the stack is empty, only the threshold applies. This lets a more urgent arrival preempt the interrupt in service.
- R4: An acknowledge read made while the candidate qualifies returns the candidate's ID on `ack_id` in the same cycle. It pulses `dist_ack_valid` with that ID, and from the next cycle the running priority equals the claimed priority.
- R5: An acknowledge read made while no candidate qualifies returns 1023, raises no distributor notification, and leaves the running priority unchanged.
- R6: In the cycle after any acknowledge read, the IRQ output is low. It may rise again one cycle later.
- R7: An end-of-interrupt write whose ID equals the ID on top of the stack pops that entry. The running priority then reverts to the entry below, or to 255 when the stack empties.
- R8: An end-of-interrupt write whose ID differs from the top entry's ID, or that arrives when the stack is empty, has no effect on the running priority.
- R9: The stack holds 4 entries. When it is full, the IRQ output stays low and an acknowledge read returns 1023.
- R10: A threshold write takes effect from the next cycle. The IRQ decision of the same cycle still uses the old threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cand_valid | input | 1 | Distributor presents a candidate |
| cand_id | input | 10 | Candidate interrupt ID |
| cand_prio | input | 8 | Candidate priority value (lower is more urgent) |
| mask_wr | input | 1 | Threshold write strobe |
| mask_wdata | input | 8 | New threshold value |
| ack_rd | input | 1 | Acknowledge read strobe |
| ack_id | output | 10 | Acknowledge read data: claimed ID, or 1023 |
| eoi_wr | input | 1 | End-of-interrupt write strobe |
| eoi_id | input | 10 | ID named by the end-of-interrupt write |
| irq_out | output | 1 | Interrupt request to the core |
| dist_ack_valid | output | 1 | Claim notification to the distributor |
| dist_ack_id | output | 10 | ID claimed |
| running_prio | output | 8 | Priority of the top active entry, 255 when idle |

## Verification
The bench targets three boundaries. The first is equality against the threshold and against the running priority: a design using a non-strict comparison would raise IRQ for a candidate equal to the threshold, or let an equal-priority interrupt nest. The second is the full stack: a design without the full check would accept a fifth claim and lose the oldest running priority. The third is acknowledge reads made with no qualifying candidate, which a faulty design would answer with a stale ID or use to push the stack. Mismatched and empty-stack end-of-interrupt writes are also covered; a design that popped regardless would show the running priority dropping early. Random traffic with interleaved threshold writes checks the one-cycle IRQ latency and the forced low cycle after each acknowledge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   // Policy for how an end-of-interrupt write selects the entry to retire.
   typedef enum logic {
      EOI_POP_TOP_ANY  = 1'b0,
      EOI_POP_ON_MATCH = 1'b1
   } eoi_policy_e;
endpackage

// File: rtl/irqc_prio_stack.sv
module irqc_prio_stack #(
   parameter int DEPTH  = 4,
   parameter int PRIO_W = 8,
   parameter int ID_W   = 10
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push,
   input  logic                         pop,
   input  logic [PRIO_W-1:0]            push_prio,
   input  logic [ID_W-1:0]              push_id,
   output logic [PRIO_W-1:0]            top_prio,
   output logic [ID_W-1:0]              top_id,
   output logic [$clog2(DEPTH+1)-1:0]   level,
   output logic                         empty,
   output logic                         full
);
   localparam int LVL_W = $clog2(DEPTH+1);
   localparam logic [PRIO_W-1:0] IDLE_PRIO = {PRIO_W{1'b1}};

   if (DEPTH < 1) begin : g_bad_depth
      $error("irqc_prio_stack: DEPTH must be at least 1");
   end

   logic [LVL_W-1:0]  lvl_q;
   logic [PRIO_W-1:0] ent_p [DEPTH];
   logic [ID_W-1:0]   ent_i [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= '0;
      end else if (push && !pop) begin
         lvl_q <= lvl_q + LVL_W'(1);
      end else if (pop && !push) begin
         lvl_q <= lvl_q - LVL_W'(1);
      end
   end

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
      logic wr_here;
      // Plain push writes slot lvl; push with pop replaces the top slot.
      assign wr_here = push && ((!pop && (lvl_q == LVL_W'(gi))) ||
                                ( pop && (lvl_q == LVL_W'(gi + 1))));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_p[gi] <= IDLE_PRIO;
            ent_i[gi] <= '0;
         end else if (wr_here) begin
            ent_p[gi] <= push_prio;
            ent_i[gi] <= push_id;
         end
      end
   end

   always_comb begin
      top_prio = IDLE_PRIO;
      top_id   = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (lvl_q == LVL_W'(i + 1)) begin
            top_prio = ent_p[i];
            top_id   = ent_i[i];
         end
      end
   end

   assign level = lvl_q;
   assign empty = (lvl_q == '0);
   assign full  = (lvl_q == LVL_W'(DEPTH));
endmodule

// File: rtl/irqc_gate.sv
module irqc_gate #(
   parameter int PRIO_W = 8
) (
   input  logic              cand_valid,
   input  logic [PRIO_W-1:0] cand_prio,
   input  logic [PRIO_W-1:0] mask,
   input  logic [PRIO_W-1:0] run_prio,
   input  logic              stk_empty,
   input  logic              stk_full,
   output logic              pass_mask,
   output logic              pass_preempt,
   output logic              signallable
);
   if (PRIO_W < 1 || PRIO_W > 16) begin : g_bad_prio
      $error("irqc_gate: PRIO_W out of range");
   end

   assign pass_mask    = cand_valid && (cand_prio < mask);
   assign pass_preempt = stk_empty || (cand_prio < run_prio);
   assign signallable  = pass_mask && pass_preempt && !stk_full;
endmodule

// File: rtl/irq_cpu_gate.sv
module irq_cpu_gate
   import irqc_pkg::*;
#(
   parameter int          ID_W        = 10,
   parameter int          PRIO_W      = 8,
   parameter int          STACK_DEPTH = 4,
   parameter eoi_policy_e EOI_POLICY  = EOI_POP_ON_MATCH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cand_valid,
   input  logic [ID_W-1:0]   cand_id,
   input  logic [PRIO_W-1:0] cand_prio,
   input  logic              mask_wr,
   input  logic [PRIO_W-1:0] mask_wdata,
   input  logic              ack_rd,
   output logic [ID_W-1:0]   ack_id,
   input  logic              eoi_wr,
   input  logic [ID_W-1:0]   eoi_id,
   output logic              irq_out,
   output logic              dist_ack_valid,
   output logic [ID_W-1:0]   dist_ack_id,
   output logic [PRIO_W-1:0] running_prio
);
   localparam int              LVL_W       = $clog2(STACK_DEPTH + 1);
   localparam logic [ID_W-1:0] SPURIOUS_ID = {ID_W{1'b1}};

   if (ID_W < 2) begin : g_bad_id
      $error("irq_cpu_gate: ID_W must be at least 2");
   end

   logic [PRIO_W-1:0] mask_q;
   logic              irq_q;
   logic [PRIO_W-1:0] stk_top_prio;
   logic [ID_W-1:0]   stk_top_id;
   logic [LVL_W-1:0]  stk_level;
   logic              stk_empty, stk_full;
   logic              pass_mask, pass_preempt, sig;
   logic              claim, retire, eoi_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '0;
      else if (mask_wr) mask_q <= mask_wdata;
   end

   irqc_gate #(.PRIO_W(PRIO_W)) u_gate (
      .cand_valid  (cand_valid),
      .cand_prio   (cand_prio),
      .mask        (mask_q),
      .run_prio    (stk_top_prio),
      .stk_empty   (stk_empty),
      .stk_full    (stk_full),
      .pass_mask   (pass_mask),
      .pass_preempt(pass_preempt),
      .signallable (sig)
   );

   if (EOI_POLICY == EOI_POP_ON_MATCH) begin : g_eoi_match
      assign eoi_hit = (eoi_id == stk_top_id);
   end else begin : g_eoi_any
      assign eoi_hit = 1'b1;
   end

   assign claim  = ack_rd && sig;
   assign retire = eoi_wr && !stk_empty && eoi_hit;

   irqc_prio_stack #(
      .DEPTH (STACK_DEPTH),
      .PRIO_W(PRIO_W),
      .ID_W  (ID_W)
   ) u_stack (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (claim),
      .pop      (retire),
      .push_prio(cand_prio),
      .push_id  (cand_id),
      .top_prio (stk_top_prio),
      .top_id   (stk_top_id),
      .level    (stk_level),
      .empty    (stk_empty),
      .full     (stk_full)
   );

   // Re-evaluated every cycle; forced low for the cycle after an acknowledge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= sig && !ack_rd;
   end

   assign irq_out        = irq_q;
   assign ack_id         = sig ? cand_id : SPURIOUS_ID;
   assign dist_ack_valid = claim;
   assign dist_ack_id    = cand_id;
   assign running_prio   = stk_top_prio;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
   parameter int ID_W        = 10,
   parameter int PRIO_W      = 8,
   parameter int STACK_DEPTH = 4
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             cand_valid,
   input logic [PRIO_W-1:0]                cand_prio,
   input logic [PRIO_W-1:0]                mask_q,
   input logic [$clog2(STACK_DEPTH+1)-1:0] level,
   input logic [PRIO_W-1:0]                top_prio,
   input logic                             ack_rd,
   input logic [ID_W-1:0]                  ack_id,
   input logic                             dist_ack_valid,
   input logic                             eoi_wr,
   input logic                             irq_out,
   input logic [PRIO_W-1:0]                running_prio
);
   localparam int LVL_W = $clog2(STACK_DEPTH + 1);

   p_mask_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> $past(cand_valid && (cand_prio < mask_q)));

   p_preempt_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> $past((level == '0) || (cand_prio < top_prio)));

   p_claim_prio_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dist_ack_valid && !eoi_wr) |=> (running_prio == $past(cand_prio)));

   p_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rd && !dist_ack_valid) |-> (ack_id == {ID_W{1'b1}}));

   p_irq_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ack_rd |=> !irq_out);

   p_idle_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (level == '0) |-> (running_prio == {PRIO_W{1'b1}}));

   p_full_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (level == LVL_W'(STACK_DEPTH)) |-> !dist_ack_valid);

   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_W'(STACK_DEPTH));
endmodule

bind irq_cpu_gate irqc_checker #(
   .ID_W       (ID_W),
   .PRIO_W     (PRIO_W),
   .STACK_DEPTH(STACK_DEPTH)
) u_irqc_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .cand_valid    (cand_valid),
   .cand_prio     (cand_prio),
   .mask_q        (mask_q),
   .level         (stk_level),
   .top_prio      (stk_top_prio),
   .ack_rd        (ack_rd),
   .ack_id        (ack_id),
   .dist_ack_valid(dist_ack_valid),
   .eoi_wr        (eoi_wr),
   .irq_out       (irq_out),
   .running_prio  (running_prio)
);

// File: tb/test_irq_cpu_gate.sv
`timescale 1ns/1ps
module test_irq_cpu_gate;
   localparam int ID_W = 10, PRIO_W = 8, DEPTH = 4;
   localparam int SPUR = 1023, IDLE = 255;

   logic              clk = 1'b0, rst_n = 1'b0;
   logic              cand_valid = 1'b0, mask_wr = 1'b0, ack_rd = 1'b0, eoi_wr = 1'b0;
   logic [ID_W-1:0]   cand_id = '0, eoi_id = '0;
   logic [PRIO_W-1:0] cand_prio = '0, mask_wdata = '0;
   logic [ID_W-1:0]   ack_id, dist_ack_id;
   logic              irq_out, dist_ack_valid;
   logic [PRIO_W-1:0] running_prio;

   int n_chk = 0, n_fail = 0;
   int m_mask = 0, m_cnt = 0, m_irq = 0;
   int m_p[DEPTH], m_id[DEPTH];
   bit done = 0;

   always #4 clk = ~clk;

   irq_cpu_gate i_irq_cpu_gate (
      .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_id(cand_id),
      .cand_prio(cand_prio), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
      .ack_rd(ack_rd), .ack_id(ack_id), .eoi_wr(eoi_wr), .eoi_id(eoi_id),
      .irq_out(irq_out), .dist_ack_valid(dist_ack_valid),
      .dist_ack_id(dist_ack_id), .running_prio(running_prio));

   function automatic int run_p();
      return (m_cnt == 0) ? IDLE : m_p[m_cnt-1];
   endfunction

   function automatic bit model_sig(bit v, int p);
      return v && (p < m_mask) && (m_cnt == 0 || p < run_p()) && (m_cnt < DEPTH);
   endfunction

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step(bit v, int id, int p, bit mw, int md, bit ack, bit eoi, int eid);
      bit s, pop, push;
      cand_valid = v; cand_id = ID_W'(id); cand_prio = PRIO_W'(p);
      mask_wr = mw; mask_wdata = PRIO_W'(md); ack_rd = ack; eoi_wr = eoi; eoi_id = ID_W'(eid);
      #1;
      s = model_sig(v, p);
      if (ack) begin
         chk("R4 R5 R9 ack_id", int'(ack_id), s ? id : SPUR);
         chk("R4 R5 dist_ack_valid", int'(dist_ack_valid), int'(s));
         if (s) chk("R4 dist_ack_id", int'(dist_ack_id), id);
      end
      @(posedge clk);
      pop  = eoi && m_cnt > 0 && eid == m_id[m_cnt-1];
      push = ack && s;
      if (pop && push) begin m_p[m_cnt-1] = p; m_id[m_cnt-1] = id; end
      else if (pop) m_cnt--;
      else if (push) begin m_p[m_cnt] = p; m_id[m_cnt] = id; m_cnt++; end
      if (mw) m_mask = md;
      m_irq = (s && !ack) ? 1 : 0;
      @(negedge clk);
      chk("R2 R3 R6 R9 R10 irq_out", int'(irq_out), m_irq);
      chk("R4 R7 R8 running_prio", int'(running_prio), run_p());
      cand_valid = 0; mask_wr = 0; ack_rd = 0; eoi_wr = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7321));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state, all masked
      chk("R1 irq_out", int'(irq_out), 0);
      chk("R1 running_prio", int'(running_prio), IDLE);
      step(1, 5, 0, 0, 0, 1, 0, 0);            // R1: ack returns 1023 under mask 0
      // R10: threshold write seen only from next cycle
      step(1, 7, 16, 1, 128, 0, 0, 0);
      step(1, 7, 128, 0, 0, 0, 0, 0);          // R2: equal value blocked
      step(1, 7, 127, 0, 0, 0, 0, 0);          // R2: strictly below passes
      step(1, 7, 127, 0, 0, 1, 0, 0);          // R4 R6: claim
      step(1, 8, 127, 0, 0, 0, 0, 0);          // R3: equal to running blocked
      step(1, 8, 64, 0, 0, 0, 0, 0);           // R3: preempt
      step(1, 8, 64, 0, 0, 1, 0, 0);
      step(1, 9, 32, 0, 0, 1, 0, 0);
      step(1, 10, 16, 0, 0, 1, 0, 0);          // stack now full
      step(1, 11, 0, 0, 0, 0, 0, 0);           // R9: irq held low
      step(1, 11, 0, 0, 0, 1, 0, 0);           // R9 R5: ack returns 1023
      step(0, 0, 0, 0, 0, 0, 1, 9);            // R8: wrong id ignored
      step(0, 0, 0, 0, 0, 0, 1, 10);           // R7: pop to 32
      step(0, 0, 0, 0, 0, 0, 1, 9);
      step(0, 0, 0, 0, 0, 0, 1, 8);
      step(0, 0, 0, 0, 0, 0, 1, 7);            // R7: back to idle
      step(0, 0, 0, 0, 0, 0, 1, 7);            // R8: empty stack ignored
      // random traffic
      for (int k = 0; k < 3000; k++) begin
         int p, id, eid;
         bit v, mw, ack, eoi;
         v   = ($urandom % 8) != 0;
         p   = (($urandom % 4) == 0) ? m_mask : ($urandom % 256);
         id  = $urandom % 1023;
         mw  = ($urandom % 16) == 0;
         ack = ($urandom % 3) == 0;
         eoi = ($urandom % 4) == 0;
         eid = (m_cnt > 0 && ($urandom % 4) != 0) ? m_id[m_cnt-1] : ($urandom % 1024);
         step(v, id, p, mw, 64 + ($urandom % 192), ack, eoi, eid);
      end
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule